// File: doc/BRIEF.md
# Frame-Carried GPIO Port

This block runs the general-purpose pins of a codec that a signal processor controls over a synchronous serial link. That link carries two kinds of frames: primary and secondary. The port has eight bidirectional pins, and registers hold each pin's direction and output data. A ninth pin is output-only. It follows one bit of every incoming primary word and needs no setup.

Pin state goes back to the processor inside the serial frames themselves. Each outgoing secondary word carries the status of all eight pins in its upper byte and the addressed control register in its lower byte. When an overlay enable is set, the status of pins 0 and 1 replaces the two least significant bits of each outgoing primary ADC word. Pad inputs pass through a two-stage synchronizer before they reach any frame field. For a pin driven as an output, the status bit reports the stored data value instead of the pad level.

Top module: `gpio_frame_port`

## Requirements
- R1: After reset the direction register holds 8'hFF (bit value 1 = input), so `pad_oe` is 8'h00. The data register and `direct_out` are 0.
- R2: A write with `cfg_wr_en`=1 and `cfg_wr_sel`=0 loads the direction register from `cfg_wr_data`. From the next clock edge, `pad_oe` equals the bitwise inverse of the written value.
- R3: A write with `cfg_wr_sel`=1 loads the data register, which appears on `pad_out` after the next edge. Writing data while a pin is an input leaves that pin's `pad_oe` at 0. Switching the pin to output later drives the stored value with no new data write.
- R4: On a clock edge where `pri_rx_valid` is 1, `direct_out` takes bit 1 of `pri_rx_word`. Otherwise `direct_out` holds its value.
- R5: With `ovl_en`=1, `pri_tx_word` equals `pri_adc_word` with bits [1:0] replaced by the status of pins 1 and 0, in that order.
- R6: With `ovl_en`=0, `pri_tx_word` equals `pri_adc_word` unchanged.
- R7: `sec_tx_word` is {pin status[7:0], `sec_ctrl_byte`[7:0]}, with status in bits [15:8].
- R8: The status bit of a pin set as an output equals its data-register bit, whatever level is on its pad.
- R9: The status bit of an input pin follows `pad_in` two clock edges after the pad changes. After only one edge it still shows the old level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 1 | Write target: 0 = direction, 1 = data |
| cfg_wr_data | input | 8 | Write value |
| ovl_en | input | 1 | Enables the two-bit status overlay on primary ADC words |
| pri_rx_valid | input | 1 | An incoming primary data word is present |
| pri_rx_word | input | 16 | Incoming primary data word |
| pri_adc_word | input | 16 | ADC word bound for the outgoing primary frame |
| sec_ctrl_byte | input | 8 | Contents of the addressed control register |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_out | output | 8 | Pad output data |
| pad_oe | output | 8 | Pad output enables, 1 = drive |
| direct_out | output | 1 | Output-only pin |
| pri_tx_word | output | 16 | Outgoing primary word |
| sec_tx_word | output | 16 | Outgoing secondary word |

## Verification
The hardest case to reach is an input pin seen in the middle of its synchronizer delay, one edge after the pad changed. The bench first holds the pad steady for several edges, then changes it at a falling edge and samples the secondary word after the next rising edge and again after the one after that. A second hard case is a pin whose status must come from the data register while the pad carries the opposite level. The stimulus table covers it by driving pad values that are the complement of the written data on output pins.

// File: rtl/gpio_frame_pkg.sv
package gpio_frame_pkg;

  localparam int PINS      = 8;
  localparam int WORD_W    = 16;
  localparam int OVL_BITS  = 2;
  localparam int DIRECT_BIT = 1;

  // Per-pin status: inputs report the synchronized pad, outputs the stored data.
  function automatic logic [PINS-1:0] pin_status_f(
    input logic [PINS-1:0] dir_is_in,
    input logic [PINS-1:0] pad_sync,
    input logic [PINS-1:0] data_reg
  );
    return (dir_is_in & pad_sync) | (~dir_is_in & data_reg);
  endfunction

  // Replace the low status bits of a primary ADC word when enabled.
  function automatic logic [WORD_W-1:0] overlay_f(
    input logic [WORD_W-1:0]   adc,
    input logic [OVL_BITS-1:0] st,
    input logic                en
  );
    logic [WORD_W-1:0] w;
    w = adc;
    if (en) w[OVL_BITS-1:0] = st;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] sec_pack_f(
    input logic [PINS-1:0]        st,
    input logic [WORD_W-PINS-1:0] ctrl
  );
    return {st, ctrl};
  endfunction

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs #(
  parameter int PINS       = 8,
  parameter int WORD_W     = 16,
  parameter int DIRECT_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [PINS-1:0]   wr_data,
  input  logic              rx_valid,
  input  logic [WORD_W-1:0] rx_word,
  output logic [PINS-1:0]   dir_q,
  output logic [PINS-1:0]   data_q,
  output logic              direct_q
);
  logic dir_wr, data_wr;
  assign dir_wr  = wr_en && !wr_sel;
  assign data_wr = wr_en &&  wr_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q    <= '1;
      data_q   <= '0;
      direct_q <= 1'b0;
    end else begin
      if (dir_wr)   dir_q    <= wr_data;
      if (data_wr)  data_q   <= wr_data;
      if (rx_valid) direct_q <= rx_word[DIRECT_BIT];
    end
  end
endmodule

// File: rtl/gpio_frame_mux.sv
module gpio_frame_mux
  import gpio_frame_pkg::*;
(
  input  logic [PINS-1:0]        dir_q,
  input  logic [PINS-1:0]        data_q,
  input  logic [PINS-1:0]        pad_sync,
  input  logic                   ovl_en,
  input  logic [WORD_W-1:0]      adc_word,
  input  logic [WORD_W-PINS-1:0] ctrl_byte,
  output logic [PINS-1:0]        status,
  output logic [WORD_W-1:0]      pri_word,
  output logic [WORD_W-1:0]      sec_word
);
  always_comb begin
    status   = pin_status_f(dir_q, pad_sync, data_q);
    pri_word = overlay_f(adc_word, status[OVL_BITS-1:0], ovl_en);
    sec_word = sec_pack_f(status, ctrl_byte);
  end
endmodule

// File: rtl/gpio_frame_port.sv
module gpio_frame_port
  import gpio_frame_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr_en,
  input  logic        cfg_wr_sel,
  input  logic [7:0]  cfg_wr_data,
  input  logic        ovl_en,
  input  logic        pri_rx_valid,
  input  logic [15:0] pri_rx_word,
  input  logic [15:0] pri_adc_word,
  input  logic [7:0]  sec_ctrl_byte,
  input  logic [7:0]  pad_in,
  output logic [7:0]  pad_out,
  output logic [7:0]  pad_oe,
  output logic        direct_out,
  output logic [15:0] pri_tx_word,
  output logic [15:0] sec_tx_word
);
  logic [PINS-1:0] dir_q, data_q, pad_sync, pin_status;

  gpio_pad_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_sync)
  );

  gpio_ctrl_regs #(.PINS(PINS), .WORD_W(WORD_W), .DIRECT_BIT(DIRECT_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel), .wr_data(cfg_wr_data),
    .rx_valid(pri_rx_valid), .rx_word(pri_rx_word),
    .dir_q(dir_q), .data_q(data_q), .direct_q(direct_out)
  );

  gpio_frame_mux u_mux (
    .dir_q(dir_q), .data_q(data_q), .pad_sync(pad_sync),
    .ovl_en(ovl_en), .adc_word(pri_adc_word), .ctrl_byte(sec_ctrl_byte),
    .status(pin_status), .pri_word(pri_tx_word), .sec_word(sec_tx_word)
  );

  assign pad_oe  = ~dir_q;
  assign pad_out = data_q;
endmodule

// File: rtl/gpio_frame_port_chk.sv
module gpio_frame_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr_en,
  input logic        cfg_wr_sel,
  input logic [7:0]  cfg_wr_data,
  input logic        ovl_en,
  input logic        pri_rx_valid,
  input logic [15:0] pri_rx_word,
  input logic [15:0] pri_adc_word,
  input logic [7:0]  sec_ctrl_byte,
  input logic [7:0]  pad_out,
  input logic [7:0]  pad_oe,
  input logic        direct_out,
  input logic [15:0] pri_tx_word,
  input logic [15:0] sec_tx_word
);
  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && !cfg_wr_sel) |=> (pad_oe == ~$past(cfg_wr_data)));

  assert_data_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_wr_sel) |=> (pad_out == $past(cfg_wr_data)));

  assert_direct_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pri_rx_valid |=> (direct_out == $past(pri_rx_word[1])));

  assert_direct_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pri_rx_valid |=> $stable(direct_out));

  assert_overlay_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pri_tx_word[15:2] == pri_adc_word[15:2]);

  assert_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ovl_en |-> (pri_tx_word == pri_adc_word));

  assert_sec_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tx_word[7:0] == sec_ctrl_byte);

  assert_out_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tx_word[15:8] & pad_oe) == (pad_out & pad_oe));
endmodule

bind gpio_frame_port gpio_frame_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
  .cfg_wr_data(cfg_wr_data), .ovl_en(ovl_en), .pri_rx_valid(pri_rx_valid),
  .pri_rx_word(pri_rx_word), .pri_adc_word(pri_adc_word),
  .sec_ctrl_byte(sec_ctrl_byte), .pad_out(pad_out), .pad_oe(pad_oe),
  .direct_out(direct_out), .pri_tx_word(pri_tx_word), .sec_tx_word(sec_tx_word)
);

// File: tb/tb_gpio_frame_port.sv
module tb_gpio_frame_port;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 4;

  typedef struct packed {
    logic [7:0]  dir;
    logic [7:0]  data;
    logic [7:0]  pad;
    logic        ovl;
    logic [15:0] adc;
    logic [7:0]  ctrl;
    logic [15:0] exp_pri;
    logic [15:0] exp_sec;
  } vec_t;

  // dir bit 1 = input; status = input ? pad : data
  localparam vec_t VECS [NVEC] = '{
    '{8'hFF, 8'h00, 8'hA5, 1'b1, 16'h1234, 8'h3C, 16'h1235, 16'hA53C},
    '{8'h00, 8'h5A, 8'hA5, 1'b1, 16'hFFFF, 8'h00, 16'hFFFE, 16'h5A00},
    '{8'hF0, 8'h0F, 8'h33, 1'b0, 16'h8001, 8'h81, 16'h8001, 16'h3F81},
    '{8'h0F, 8'hC3, 8'h96, 1'b1, 16'h0001, 8'h7E, 16'h0002, 16'hC67E}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0, cfg_wr_sel = 1'b0;
  logic [7:0]  cfg_wr_data = '0;
  logic        ovl_en = 1'b0, pri_rx_valid = 1'b0;
  logic [15:0] pri_rx_word = '0, pri_adc_word = '0;
  logic [7:0]  sec_ctrl_byte = '0, pad_in = '0;
  logic [7:0]  pad_out, pad_oe;
  logic        direct_out;
  logic [15:0] pri_tx_word, sec_tx_word;

  int checks = 0;
  int errors = 0;

  gpio_frame_port dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [7:0] val);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = val;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic rx_word(input logic valid, input logic [15:0] w);
    @(negedge clk);
    pri_rx_valid = valid; pri_rx_word = w;
    @(negedge clk);
    pri_rx_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 oe", {8'h0, pad_oe}, 16'h0000);
    check("R1 out", {8'h0, pad_out}, 16'h0000);
    check("R1 direct", {15'h0, direct_out}, 16'h0000);

    // Vector table: R2 R5 R6 R7 R8
    for (int i = 0; i < NVEC; i++) begin
      cfg_write(1'b0, VECS[i].dir);
      cfg_write(1'b1, VECS[i].data);
      pad_in = VECS[i].pad; ovl_en = VECS[i].ovl;
      pri_adc_word = VECS[i].adc; sec_ctrl_byte = VECS[i].ctrl;
      repeat (3) @(negedge clk);
      check("R2 oe", {8'h0, pad_oe}, {8'h0, ~VECS[i].dir});
      check("R3 out", {8'h0, pad_out}, {8'h0, VECS[i].data});
      check(VECS[i].ovl ? "R5 pri" : "R6 pri", pri_tx_word, VECS[i].exp_pri);
      check("R7 R8 sec", sec_tx_word, VECS[i].exp_sec);
    end

    // R3: data written while input is held, driven once switched to output
    cfg_write(1'b0, 8'hFF);
    cfg_write(1'b1, 8'h81);
    check("R3 oe while input", {8'h0, pad_oe}, 16'h0000);
    cfg_write(1'b0, 8'h7E);
    check("R3 oe after switch", {8'h0, pad_oe}, 16'h0081);
    check("R3 out after switch", {8'h0, pad_out}, 16'h0081);

    // R4: output-only pin follows bit 1 of valid primary words
    rx_word(1'b1, 16'h0002);
    check("R4 load 1", {15'h0, direct_out}, 16'h0001);
    rx_word(1'b0, 16'h0000);
    check("R4 hold", {15'h0, direct_out}, 16'h0001);
    rx_word(1'b1, 16'hFFFD);
    check("R4 load 0", {15'h0, direct_out}, 16'h0000);

    // R9: two-edge synchronizer delay on inputs
    cfg_write(1'b0, 8'hFF);
    pad_in = 8'h00;
    repeat (4) @(negedge clk);
    pad_in = 8'hFF;
    @(negedge clk);
    check("R9 after one edge", {8'h0, sec_tx_word[15:8]}, 16'h0000);
    @(negedge clk);
    check("R9 after two edges", {8'h0, sec_tx_word[15:8]}, 16'h00FF);

    // R8: output pin ignores opposite pad level
    cfg_write(1'b1, 8'h00);
    cfg_write(1'b0, 8'h00);
    repeat (2) @(negedge clk);
    check("R8 output status", {8'h0, sec_tx_word[15:8]}, 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule